// File: doc/BRIEF.md
# DMA Request Handshake Controller

This block runs the request side of one DMA channel that serves an external peripheral. The peripheral's request line is first brought into the clock domain through a flop synchronizer. It is then read in one of two ways, chosen by a mode input. In level mode a held request gives back-to-back bus transfers until the peripheral withdraws it. In edge mode each detected edge moves exactly one operand. A second input sets which edges count: falling edges only, or both edges. Edge mode suits a periodic pulse source such as a timer output, which then paces the transfers.

Each transfer raises a request toward a bus-master stub. The request is held until the stub returns its transfer-acknowledge. For the whole of that bus cycle an acknowledge goes back to the peripheral. A programmable remaining-operand count falls by one per completed operand. At zero the block raises an out-of-buffers error and stops issuing transfers until software clears the flags and reloads the count. A done flag can be raised earlier, at a programmable remaining count, so that software can suspend the channel.

Top module: `dreq_hs_ctrl`

## Requirements
- R1: After reset, bus_req_o, periph_ack_o, done_o and oob_o are low and cnt_o is zero.
- R2: With level_mode_i high, a held request gives back-to-back transfers. Once the request is withdrawn, transfers cease and cnt_o stays constant.
- R3: With level_mode_i low and any_edge_i low, each falling edge of dreq_i moves exactly one operand, and rising edges start nothing.
- R4: With level_mode_i low and any_edge_i high, every edge of dreq_i, rising or falling, moves exactly one operand.
- R5: In edge mode, an edge seen while a transfer is in flight is held as one pending request. Further edges before it is served merge into it. A pending request starts a transfer as soon as the channel is idle and may run.
- R6: bus_req_o stays high until a cycle in which bus_ack_i is high. periph_ack_o is high in every cycle of a bus transfer and in no other cycle.
- R7: cnt_o falls by exactly one for each completed operand (a cycle in which bus_req_o and bus_ack_i are both high) and changes at no other time except a load.
- R8: When a completed operand brings cnt_o to zero, oob_o rises. While oob_o is high or cnt_o is zero, bus_req_o stays low.
- R9: done_o rises when a completed operand leaves cnt_o equal to done_mark_i.
- R10: A flag_clr_i pulse clears done_o and oob_o. A cnt_load_i pulse loads cnt_val_i into the count and discards any pending edge request.
- R11: dreq_i passes through a two-flop synchronizer. After a level-mode request rises, bus_req_o is first high after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| level_mode_i | input | 1 | 1 selects level requests, 0 selects edge requests |
| any_edge_i | input | 1 | Edge mode: 1 counts both edges, 0 counts falling edges only |
| dreq_i | input | 1 | Asynchronous request from the peripheral |
| bus_ack_i | input | 1 | Transfer-acknowledge from the bus stub that ends the current cycle |
| cnt_load_i | input | 1 | Loads cnt_val_i into the remaining count |
| cnt_val_i | input | CNT_W | Operand count to load |
| done_mark_i | input | CNT_W | Remaining count at which done_o rises |
| flag_clr_i | input | 1 | Clears done_o and oob_o |
| bus_req_o | output | 1 | Bus transfer request, held until bus_ack_i |
| periph_ack_o | output | 1 | Acknowledge to the peripheral during each bus cycle |
| cnt_o | output | CNT_W | Remaining operand count |
| done_o | output | 1 | Done flag, sticky |
| oob_o | output | 1 | Out-of-buffers error flag, sticky |

## Verification
Some rules are checked by assertions on every cycle. A bus request is held until the stub acknowledges it. The count moves only by one per completed operand. The last operand raises the error. No request leaves while the error is set or the count is empty. A pending edge request starts a transfer at once when the channel may run. Other behaviour shows only in the bench's scenarios. These are the synchronizer latency, the one-operand-per-edge counts under each edge setting, the merging of edges that arrive during a slow bus cycle, the end of a level burst after the request is withdrawn, and the position of the done flag.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic any_edge_i,
  output logic level_o,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];
  end

  assign level_o = sync_q[LAST];
  // falling-only or either edge
  assign edge_o  = any_edge_i ? (prev_q ^ sync_q[LAST]) : (prev_q & ~sync_q[LAST]);
endmodule

// File: rtl/dreq_cnt.sv
module dreq_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic [CNT_W-1:0] mark_i,
  input  logic             clr_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             oob_o,
  output logic             can_run_o,
  output logic             last_op_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_dec;
  logic             done_q, oob_q;
  logic             dec_ok;

  assign cnt_dec = cnt_q - ONE;
  assign dec_ok  = dec_i && !load_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      oob_q  <= 1'b0;
    end else begin
      if (load_i)      cnt_q <= val_i;
      else if (dec_ok) cnt_q <= cnt_dec;
      done_q <= (done_q & ~clr_i) | (dec_ok && (cnt_dec == mark_i));
      oob_q  <= (oob_q  & ~clr_i) | (dec_ok && (cnt_q == ONE));
    end
  end

  assign cnt_o     = cnt_q;
  assign done_o    = done_q;
  assign oob_o     = oob_q;
  assign can_run_o = !oob_q && (cnt_q != '0);
  assign last_op_o = (cnt_q == ONE);

  assert_cnt_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  assert_cnt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !load_i) |=> $stable(cnt_q));
  assert_last_sets_oob_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && cnt_q == ONE) |=> oob_q);
endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
  import dreq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_mode_i,
  input  logic req_lvl_i,
  input  logic req_edge_i,
  input  logic can_run_i,
  input  logic last_op_i,
  input  logic bus_ack_i,
  input  logic flush_i,
  output logic busy_o,
  output logic op_done_o
);
  xfer_state_e state_q, state_d;
  logic        pend_q, pend_d;
  logic        want, consume;

  assign want      = level_mode_i ? req_lvl_i : (pend_q | req_edge_i);
  assign op_done_o = (state_q == ST_BUSY) && bus_ack_i;

  always_comb begin
    state_d = state_q;
    consume = 1'b0;
    unique case (state_q)
      ST_IDLE: if (can_run_i && want) begin
        state_d = ST_BUSY;
        consume = 1'b1;
      end
      ST_BUSY: if (bus_ack_i) begin
        // level is checked on the edge that ends the cycle
        if (want && !last_op_i) consume = 1'b1;
        else                    state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (level_mode_i || flush_i) pend_d = 1'b0;
    else                         pend_d = (pend_q | req_edge_i) & ~consume;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign busy_o = (state_q == ST_BUSY);

  assert_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bus_ack_i) |=> busy_o);
  assert_pend_served_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && pend_q && can_run_i && !level_mode_i) |=> busy_o);
endmodule

// File: rtl/dreq_hs_ctrl.sv
module dreq_hs_ctrl #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_mode_i,
  input  logic             any_edge_i,
  input  logic             dreq_i,
  input  logic             bus_ack_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic [CNT_W-1:0] done_mark_i,
  input  logic             flag_clr_i,
  output logic             bus_req_o,
  output logic             periph_ack_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             oob_o
);
  logic req_lvl, req_edge, can_run, last_op, busy, op_done;

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .async_i    (dreq_i),
    .any_edge_i (any_edge_i),
    .level_o    (req_lvl),
    .edge_o     (req_edge)
  );

  dreq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .level_mode_i (level_mode_i),
    .req_lvl_i    (req_lvl),
    .req_edge_i   (req_edge),
    .can_run_i    (can_run),
    .last_op_i    (last_op),
    .bus_ack_i    (bus_ack_i),
    .flush_i      (cnt_load_i),
    .busy_o       (busy),
    .op_done_o    (op_done)
  );

  dreq_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_load_i),
    .val_i     (cnt_val_i),
    .mark_i    (done_mark_i),
    .clr_i     (flag_clr_i),
    .dec_i     (op_done),
    .cnt_o     (cnt_o),
    .done_o    (done_o),
    .oob_o     (oob_o),
    .can_run_o (can_run),
    .last_op_o (last_op)
  );

  assign bus_req_o    = busy;
  assign periph_ack_o = busy;

  assert_no_req_when_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((oob_o || cnt_o == '0) && !bus_req_o) |=> !bus_req_o);
endmodule

// File: tb/dreq_hs_ctrl_tb.sv
module dreq_hs_ctrl_tb;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          level_mode = 1'b0, any_edge = 1'b0, dreq = 1'b0, bus_ack = 1'b0;
  logic          cnt_load = 1'b0, flag_clr = 1'b0;
  logic [CW-1:0] cnt_val = '0, done_mark = '0;
  logic          bus_req, periph_ack, done, oob;
  logic [CW-1:0] cnt;

  int checks = 0, errors = 0;
  int xfers = 0, ack_delay = 0, wcnt = 0;
  int ack_mismatch = 0;

  always #4 clk = ~clk;

  dreq_hs_ctrl #(.CNT_W(CW), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .level_mode_i(level_mode), .any_edge_i(any_edge),
    .dreq_i(dreq), .bus_ack_i(bus_ack), .cnt_load_i(cnt_load), .cnt_val_i(cnt_val),
    .done_mark_i(done_mark), .flag_clr_i(flag_clr), .bus_req_o(bus_req),
    .periph_ack_o(periph_ack), .cnt_o(cnt), .done_o(done), .oob_o(oob)
  );

  // bus stub: acknowledge after ack_delay wait cycles
  always @(negedge clk) begin
    if (periph_ack !== bus_req) ack_mismatch++;
    if (bus_ack) begin
      xfers++;
      bus_ack <= 1'b0;
      wcnt = 0;
    end else if (bus_req) begin
      if (wcnt >= ack_delay) bus_ack <= 1'b1;
      else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic load(input int val, input int mark);
    cnt_val = CW'(val); done_mark = CW'(mark);
    cnt_load = 1'b1; flag_clr = 1'b1;
    tick(1);
    cnt_load = 1'b0; flag_clr = 1'b0;
    xfers = 0;
  endtask

  task automatic pulse(input int hi, input int lo);
    dreq = 1'b1; tick(hi);
    dreq = 1'b0; tick(lo);
  endtask

  task automatic t_reset();
    chk(bus_req == 0, "R1 bus_req", bus_req, 0);
    chk(periph_ack == 0, "R1 periph_ack", periph_ack, 0);
    chk(done == 0 && oob == 0, "R1 flags", {done, oob}, 0);
    chk(cnt == 0, "R1 cnt", cnt, 0);
  endtask

  task automatic t_sync_latency();
    level_mode = 1'b1; ack_delay = 0;
    load(100, 0);
    dreq = 1'b1;
    tick(1); chk(bus_req == 0, "R11 after edge1", bus_req, 0);
    tick(1); chk(bus_req == 0, "R11 after edge2", bus_req, 0);
    tick(1); chk(bus_req == 1, "R11 after edge3", bus_req, 1);
    dreq = 1'b0;
    tick(20);
  endtask

  task automatic t_level_burst();
    int snap;
    level_mode = 1'b1; ack_delay = 0;
    load(200, 0);
    dreq = 1'b1; tick(20);
    dreq = 1'b0; tick(15);
    snap = cnt;
    chk(bus_req == 0, "R2 stopped after withdraw", bus_req, 0);
    chk(xfers >= 5, "R2 back-to-back count", xfers, 5);
    tick(20);
    chk(cnt == snap, "R2 cnt stable after withdraw", cnt, snap);
    chk(xfers == 200 - cnt, "R7 one dec per operand", 200 - cnt, xfers);
  endtask

  task automatic t_level_exhaust();
    level_mode = 1'b1; ack_delay = 1;
    load(5, 99);
    dreq = 1'b1; tick(40);
    chk(xfers == 5, "R8 transfers until empty", xfers, 5);
    chk(oob == 1, "R8 oob set", oob, 1);
    chk(cnt == 0, "R8 cnt zero", cnt, 0);
    chk(bus_req == 0, "R8 no request when empty", bus_req, 0);
    dreq = 1'b0; tick(10);
  endtask

  task automatic t_falling();
    level_mode = 1'b0; any_edge = 1'b0; ack_delay = 0;
    tick(5);
    load(50, 0);
    for (int i = 0; i < 4; i++) pulse(3, 10);
    chk(xfers == 4, "R3 one per falling edge", xfers, 4);
    chk(cnt == 46, "R3 cnt", cnt, 46);
  endtask

  task automatic t_any_edge();
    level_mode = 1'b0; any_edge = 1'b1; ack_delay = 0;
    tick(5);
    load(50, 0);
    for (int i = 0; i < 4; i++) pulse(3, 10);
    chk(xfers == 8, "R4 one per edge", xfers, 8);
  endtask

  task automatic t_merge();
    level_mode = 1'b0; any_edge = 1'b1; ack_delay = 8;
    tick(5);
    load(50, 0);
    pulse(2, 2); pulse(2, 30);
    chk(xfers == 2, "R5 edges merged while busy", xfers, 2);
    chk(cnt == 48, "R5 cnt", cnt, 48);
    ack_delay = 0;
  endtask

  task automatic t_done_and_clear();
    level_mode = 1'b0; any_edge = 1'b0; ack_delay = 0;
    tick(5);
    load(6, 2);
    for (int i = 0; i < 3; i++) pulse(3, 10);
    chk(done == 0, "R9 done not yet", done, 0);
    pulse(3, 10);
    chk(done == 1 && cnt == 2, "R9 done at mark", cnt, 2);
    chk(oob == 0, "R9 no oob at mark", oob, 0);
    pulse(3, 10); pulse(3, 10);
    chk(oob == 1 && cnt == 0, "R8 oob at zero", cnt, 0);
    pulse(3, 10);
    chk(xfers == 6, "R8 edge ignored when empty", xfers, 6);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk(done == 0 && oob == 0, "R10 flags cleared", {done, oob}, 0);
    tick(5);
    chk(bus_req == 0, "R10 pending discarded on load", bus_req, 0);
    load(3, 0);
    tick(10);
    chk(xfers == 0 && cnt == 3, "R10 load drops pending", cnt, 3);
    pulse(3, 10);
    chk(xfers == 1 && cnt == 2, "R10 runs after reload", cnt, 2);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_sync_latency();
    t_level_burst();
    t_level_exhaust();
    t_falling();
    t_any_edge();
    t_merge();
    t_done_and_clear();
    chk(ack_mismatch == 0, "R6 periph_ack tracks bus cycle", ack_mismatch, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule